// File: doc/BRIEF.md
# Six-Channel Single-Line Audio Serializer/Deserializer

This block carries six audio channels on a single serial data line in each direction, driven by a bit clock and a frame-sync clock from an external master. Every frame-sync half lasts 64 bit clocks. Each half holds three consecutive 20-clock slots, so one frame holds six channels. Odd-numbered channels travel while frame sync is at the left level. Even-numbered channels travel while it is at the right level.

The transmit side takes six parallel 20-bit two's-complement samples and shifts them out on `sdout`. The receive side collects six samples from `sdin` and presents them together with a single valid pulse. The serial inputs are asynchronous to `clk`. They are resynchronized, and their edges are detected in the `clk` domain, so the bit clock must be several times slower than `clk`. With the default two synchronizer stages, each bit-clock level must last at least 5 `clk` cycles.

Top module: `tdm6_serdes`

## Requirements
- R1: After reset, `sdout` is 0, `rx_valid` is 0 and `rx_samples` is all zeros.
- R2: A half starts at each frame-sync transition, sampled on a bit-clock rising edge. That rising edge is position 0. Positions 1..20, 21..40 and 41..60 are slots 0, 1 and 2. Each slot carries 20 bits, MSB first at the slot's first position.
- R3: Channel n (1-based) sits at bits [20n-1 : 20n-20] of the flat sample ports. `fsync` = 1 is the left half, which carries channels 1, 3 and 5 in slots 0, 1 and 2. `fsync` = 0 is the right half, which carries channels 2, 4 and 6 in slots 0, 1 and 2.
- R4: `sdout` changes only after a detected bit-clock falling edge, so it is stable while the bit clock is high.
- R5: At positions 0 and 61..63 of every half, `sdout` is 0.
- R6: `tx_samples` is captured only at the frame-sync transition into the left half. A change of `tx_samples` during a frame does not affect that frame and appears in the next frame.
- R7: `sdin` is sampled on bit-clock rising edges and assembled MSB first into the channel of the slot, using the same position and channel map as R2 and R3.
- R8: `rx_valid` pulses for exactly one `clk` cycle after the last bit of channel 6 is received. `rx_samples` then holds all six words and changes only in a cycle where `rx_valid` is 1.
- R9: The first bit-clock rising edge after reset only records the frame-sync level. A right half that is not preceded by a left half started at an observed transition produces no `rx_valid`. The transmit samples stay zero until the first left-half capture.
- R10: Full-scale two's-complement values pass unchanged in both directions: 0x80000, 0x7FFFF, 0xFFFFF, 0x00001 and 0x00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; serial inputs are oversampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | External bit clock |
| fsync | input | 1 | External frame sync; 1 = left half |
| sdin | input | 1 | Serial receive data line |
| sdout | output | 1 | Serial transmit data line |
| tx_samples | input | 120 | Six transmit words, channel n at [20n-1:20n-20] |
| rx_samples | output | 120 | Six received words, same packing |
| rx_valid | output | 1 | One-cycle pulse when a full received frame is presented |

## Verification
The assertions check several rules on every `clk` cycle:
- `sdout` moves only right after a detected bit-clock fall.
- The transmit holding register changes only at a left-half start.
- `rx_valid` is a lone pulse that follows a right-half rising edge.
- `rx_samples` never changes outside a valid pulse.

Only the bench scenarios can show the slot-to-channel map, the MSB-first bit order, the zero gap positions, and capture timing when `tx_samples` moves mid-frame. The same holds for suppression of a frame entered after reset in its left half and for the full-scale values.

// File: rtl/tdm6_pkg.sv
package tdm6_pkg;

  // True when a half-frame position lies inside one of the data slots.
  function automatic bit pos_in_slot(input int pos, input int slots, input int slot_clks);
    return (pos >= 1) && (pos <= slots * slot_clks);
  endfunction

  // Slot index (0-based) of a position inside the data area.
  function automatic int pos_slot(input int pos, input int slot_clks);
    return (pos - 1) / slot_clks;
  endfunction

  // Bit index within the sample word, MSB travelling first.
  function automatic int pos_bit(input int pos, input int slot_clks);
    return slot_clks - 1 - ((pos - 1) % slot_clks);
  endfunction

  // Channel index (0-based): left half carries even indices, right half odd.
  function automatic int slot_chan(input int slot, input bit left);
    return left ? (2 * slot) : (2 * slot + 1);
  endfunction

  // Saturating position step.
  function automatic int step_pos(input int pos, input int pos_max);
    return (pos >= pos_max) ? pos_max : pos + 1;
  endfunction

endpackage

// File: rtl/tdm6_edge_sync.sv
module tdm6_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic fsync_i,
  input  logic sdin_i,
  output logic bclk_rise,
  output logic bclk_fall,
  output logic fsync_s,
  output logic sdin_s
);
  localparam int NSIG = 3;

  logic [STAGES-1:0][NSIG-1:0] stg;
  logic                        bclk_q;

  generate
    if (STAGES < 2) begin : g_bad_stages
      $error("tdm6_edge_sync needs at least two synchronizer stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg    <= '0;
      bclk_q <= 1'b0;
    end else begin
      stg[0] <= {sdin_i, fsync_i, bclk_i};
      for (int i = 1; i < STAGES; i++) begin
        stg[i] <= stg[i-1];
      end
      bclk_q <= stg[STAGES-1][0];
    end
  end

  assign bclk_rise = stg[STAGES-1][0] & ~bclk_q;
  assign bclk_fall = ~stg[STAGES-1][0] & bclk_q;
  assign fsync_s   = stg[STAGES-1][1];
  assign sdin_s    = stg[STAGES-1][2];
endmodule

// File: rtl/tdm6_frame_timer.sv
module tdm6_frame_timer
  import tdm6_pkg::*;
#(
  parameter int POS_W      = 7,
  parameter bit LEFT_LEVEL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_rise,
  input  logic             fsync_s,
  output logic [POS_W-1:0] pos_q,
  output logic             left_q,
  output logic [POS_W-1:0] rise_pos,
  output logic             rise_left,
  output logic             left_start
);
  localparam int POS_MAX = (2 ** POS_W) - 1;

  logic armed;
  logic fs_prev;
  logic half_start;

  // A half begins at the first rising edge that sees a new frame-sync level.
  assign half_start = bclk_rise && armed && (fsync_s != fs_prev);
  assign left_start = half_start && (fsync_s == LEFT_LEVEL);

  // Position and side that apply to the current rising edge.
  assign rise_pos  = half_start ? '0 : POS_W'(step_pos(int'(pos_q), POS_MAX));
  assign rise_left = half_start ? (fsync_s == LEFT_LEVEL) : left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      fs_prev <= 1'b0;
      pos_q   <= '1;
      left_q  <= 1'b0;
    end else if (bclk_rise) begin
      armed   <= 1'b1;
      fs_prev <= fsync_s;
      pos_q   <= rise_pos;
      left_q  <= rise_left;
    end
  end
endmodule

// File: rtl/tdm6_tx_lane.sv
module tdm6_tx_lane
  import tdm6_pkg::*;
#(
  parameter int  SLOTS     = 3,
  parameter int  SLOT_CLKS = 20,
  parameter int  POS_W     = 7,
  localparam int FRAME_W   = 2 * SLOTS * SLOT_CLKS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               left_start,
  input  logic               bclk_fall,
  input  logic [POS_W-1:0]   pos_q,
  input  logic               left_q,
  input  logic [FRAME_W-1:0] tx_samples,
  output logic               sdout,
  output logic [FRAME_W-1:0] hold_flat
);
  localparam int CHANS   = 2 * SLOTS;
  localparam int CH_W    = $clog2(CHANS);
  localparam int BIT_W   = $clog2(SLOT_CLKS);
  localparam int POS_MAX = (2 ** POS_W) - 1;

  logic [CHANS-1:0][SLOT_CLKS-1:0] hold;
  logic [POS_W-1:0]                drv_pos;
  logic                            drv_active;
  logic [CH_W-1:0]                 drv_ch;
  logic [BIT_W-1:0]                drv_bit;
  logic                            drv_val;

  // The bit for the position of the coming rising edge is chosen at each fall.
  always_comb begin
    drv_pos    = POS_W'(step_pos(int'(pos_q), POS_MAX));
    drv_active = pos_in_slot(int'(drv_pos), SLOTS, SLOT_CLKS);
    drv_ch     = CH_W'(slot_chan(pos_slot(int'(drv_pos), SLOT_CLKS), left_q));
    drv_bit    = BIT_W'(pos_bit(int'(drv_pos), SLOT_CLKS));
    drv_val    = drv_active ? hold[drv_ch][drv_bit] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold  <= '0;
      sdout <= 1'b0;
    end else begin
      if (left_start) begin
        hold <= tx_samples;
      end
      if (bclk_fall) begin
        sdout <= drv_val;
      end
    end
  end

  assign hold_flat = hold;
endmodule

// File: rtl/tdm6_rx_lane.sv
module tdm6_rx_lane
  import tdm6_pkg::*;
#(
  parameter int  SLOTS     = 3,
  parameter int  SLOT_CLKS = 20,
  parameter int  POS_W     = 7,
  localparam int FRAME_W   = 2 * SLOTS * SLOT_CLKS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bclk_rise,
  input  logic [POS_W-1:0]   rise_pos,
  input  logic               rise_left,
  input  logic               left_start,
  input  logic               sdin_s,
  output logic [FRAME_W-1:0] rx_samples,
  output logic               rx_valid
);
  localparam int CHANS  = 2 * SLOTS;
  localparam int CH_W   = $clog2(CHANS);
  localparam int BIT_W  = $clog2(SLOT_CLKS);
  localparam int SLOT_W = $clog2(SLOTS + 1);

  logic [SLOT_CLKS-1:0]            shreg;
  logic [SLOT_CLKS-1:0]            word;
  logic [CHANS-1:0][SLOT_CLKS-1:0] stage;
  logic [CHANS-1:0][SLOT_CLKS-1:0] stage_nx;
  logic [CHANS-1:0][SLOT_CLKS-1:0] out_q;
  logic                            take;
  logic                            cap_word;
  logic                            frame_done;
  logic                            left_seen;
  logic [SLOT_W-1:0]               cur_slot;
  logic [CH_W-1:0]                 cur_ch;
  logic [BIT_W-1:0]                cur_bit;

  always_comb begin
    take     = bclk_rise && pos_in_slot(int'(rise_pos), SLOTS, SLOT_CLKS);
    word     = {shreg[SLOT_CLKS-2:0], sdin_s};
    cur_slot = SLOT_W'(pos_slot(int'(rise_pos), SLOT_CLKS));
    cur_ch   = CH_W'(slot_chan(int'(cur_slot), rise_left));
    cur_bit  = BIT_W'(pos_bit(int'(rise_pos), SLOT_CLKS));
    cap_word = take && (cur_bit == '0);
    stage_nx = stage;
    if (cap_word) begin
      stage_nx[cur_ch] = word;
    end
    frame_done = cap_word && !rise_left && left_seen &&
                 (cur_slot == SLOT_W'(SLOTS - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      stage     <= '0;
      out_q     <= '0;
      rx_valid  <= 1'b0;
      left_seen <= 1'b0;
    end else begin
      if (take) begin
        shreg <= word;
      end
      stage    <= stage_nx;
      rx_valid <= frame_done;
      if (frame_done) begin
        out_q <= stage_nx;
      end
      if (left_start) begin
        left_seen <= 1'b1;
      end else if (frame_done) begin
        left_seen <= 1'b0;
      end
    end
  end

  assign rx_samples = out_q;
endmodule

// File: rtl/tdm6_serdes.sv
module tdm6_serdes #(
  parameter int  SLOTS       = 3,
  parameter int  SLOT_CLKS   = 20,
  parameter int  HALF_CLKS   = 64,
  parameter int  SYNC_STAGES = 2,
  parameter bit  LEFT_LEVEL  = 1'b1,
  localparam int FRAME_W     = 2 * SLOTS * SLOT_CLKS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bclk,
  input  logic               fsync,
  input  logic               sdin,
  output logic               sdout,
  input  logic [FRAME_W-1:0] tx_samples,
  output logic [FRAME_W-1:0] rx_samples,
  output logic               rx_valid
);
  localparam int POS_W = $clog2(HALF_CLKS) + 1;

  generate
    if (HALF_CLKS < SLOTS * SLOT_CLKS + 1) begin : g_bad_half
      $error("tdm6_serdes: half-frame too short for its slots");
    end
  endgenerate

  logic               bclk_rise;
  logic               bclk_fall;
  logic               fsync_s;
  logic               sdin_s;
  logic [POS_W-1:0]   pos_q;
  logic               left_q;
  logic [POS_W-1:0]   rise_pos;
  logic               rise_left;
  logic               left_start;
  logic [FRAME_W-1:0] tx_hold;

  tdm6_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .bclk_i(bclk), .fsync_i(fsync), .sdin_i(sdin),
    .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
    .fsync_s(fsync_s), .sdin_s(sdin_s)
  );

  tdm6_frame_timer #(.POS_W(POS_W), .LEFT_LEVEL(LEFT_LEVEL)) timer_i (
    .clk(clk), .rst_n(rst_n),
    .bclk_rise(bclk_rise), .fsync_s(fsync_s),
    .pos_q(pos_q), .left_q(left_q),
    .rise_pos(rise_pos), .rise_left(rise_left),
    .left_start(left_start)
  );

  tdm6_tx_lane #(.SLOTS(SLOTS), .SLOT_CLKS(SLOT_CLKS), .POS_W(POS_W)) tx_i (
    .clk(clk), .rst_n(rst_n),
    .left_start(left_start), .bclk_fall(bclk_fall),
    .pos_q(pos_q), .left_q(left_q),
    .tx_samples(tx_samples),
    .sdout(sdout), .hold_flat(tx_hold)
  );

  tdm6_rx_lane #(.SLOTS(SLOTS), .SLOT_CLKS(SLOT_CLKS), .POS_W(POS_W)) rx_i (
    .clk(clk), .rst_n(rst_n),
    .bclk_rise(bclk_rise), .rise_pos(rise_pos), .rise_left(rise_left),
    .left_start(left_start), .sdin_s(sdin_s),
    .rx_samples(rx_samples), .rx_valid(rx_valid)
  );
endmodule

// File: rtl/tdm6_serdes_chk.sv
module tdm6_serdes_chk #(
  parameter int FRAME_W = 120
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bclk_rise,
  input logic               bclk_fall,
  input logic               left_start,
  input logic               rise_left,
  input logic               sdout,
  input logic               rx_valid,
  input logic [FRAME_W-1:0] rx_samples,
  input logic [FRAME_W-1:0] tx_hold
);
  // R4: the serial output moves only in the cycle after a bit-clock fall
  a_r4_sdout_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout) |-> $past(bclk_fall));

  // R6: transmit words are taken only at a left-half start
  a_r6_hold_at_left: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_hold) |-> $past(left_start));

  // R8: the valid strobe is a single-cycle pulse
  a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8: received words only move together with the valid strobe
  a_r8_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_samples) |-> rx_valid);

  // R9: a completed frame always ends on a right-half rising edge
  a_r9_valid_from_right: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(bclk_rise && !rise_left));
endmodule

bind tdm6_serdes tdm6_serdes_chk #(.FRAME_W(FRAME_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
  .left_start(left_start), .rise_left(rise_left),
  .sdout(sdout), .rx_valid(rx_valid),
  .rx_samples(rx_samples), .tx_hold(tx_hold)
);

// File: tb/tdm6_serdes_tb_top.sv
module tdm6_serdes_tb_top;
  localparam int SLOTS = 3;
  localparam int SW    = 20;
  localparam int HALF  = 64;
  localparam int CH    = 6;
  localparam int HP    = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic bclk  = 1'b0;
  logic fsync = 1'b0;
  logic sdin  = 1'b0;
  logic sdout;
  logic rx_valid;
  logic [CH-1:0][SW-1:0] tx_samples = '0;
  logic [CH-1:0][SW-1:0] rx_samples;

  tdm6_serdes dut_i (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sdin(sdin),
    .sdout(sdout), .tx_samples(tx_samples), .rx_samples(rx_samples),
    .rx_valid(rx_valid)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int vcount   = 0;
  int swap_pos = -1;
  int rel_pos  = -1;
  logic [CH-1:0][SW-1:0] vcap = '0;
  logic [CH-1:0][SW-1:0] tx_pending = '0;

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      vcount <= vcount + 1;
      vcap   <= rx_samples;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bclk = 1'b0; fsync = 1'b0; sdin = 1'b0;
      repeat (HP-1) @(negedge clk);
      @(negedge clk); bclk = 1'b1;
      repeat (HP-1) @(negedge clk);
    end
  endtask

  // One half-frame: drives sdin per position, samples sdout before each rise.
  task automatic run_half(input bit lvl, input logic [SLOTS-1:0][SW-1:0] din,
                          output logic [SLOTS-1:0][SW-1:0] got,
                          inout int zerr, inout int serr);
    got = '0;
    for (int p = 0; p < HALF; p++) begin
      bit   ins;
      int   s;
      int   b;
      logic smp;
      ins = (p >= 1) && (p <= SLOTS * SW);
      s = 0;
      b = 0;
      if (ins) begin
        s = (p - 1) / SW;
        b = SW - 1 - ((p - 1) % SW);
      end
      @(negedge clk);
      bclk  = 1'b0;
      fsync = lvl;
      sdin  = ins ? din[s][b] : 1'b0;
      if (lvl && p == swap_pos) tx_samples = tx_pending;
      if (p == rel_pos) rst_n = 1'b1;
      repeat (HP-1) @(negedge clk);
      smp = sdout;
      if (ins) got[s][b] = smp;
      else if (smp !== 1'b0) zerr++;
      @(negedge clk);
      bclk = 1'b1;
      repeat (HP-1) @(negedge clk);
      if (sdout !== smp) serr++;
    end
  endtask

  task automatic run_frame(input logic [CH-1:0][SW-1:0] rxw,
                           output logic [CH-1:0][SW-1:0] txg,
                           output int zerr, output int serr);
    logic [SLOTS-1:0][SW-1:0] dl, dr, gl, gr;
    for (int s = 0; s < SLOTS; s++) begin
      dl[s] = rxw[2*s];
      dr[s] = rxw[2*s+1];
    end
    zerr = 0;
    serr = 0;
    run_half(1'b1, dl, gl, zerr, serr);
    run_half(1'b0, dr, gr, zerr, serr);
    for (int s = 0; s < SLOTS; s++) begin
      txg[2*s]   = gl[s];
      txg[2*s+1] = gr[s];
    end
  endtask

  task automatic frame_test(input string tag, input logic [CH-1:0][SW-1:0] txw,
                            input logic [CH-1:0][SW-1:0] rxw);
    logic [CH-1:0][SW-1:0] txg;
    int z, s, v0;
    tx_samples = txw;
    v0 = vcount;
    run_frame(rxw, txg, z, s);
    for (int c = 0; c < CH; c++)
      check(txg[c] == txw[c], tag, $sformatf("tx ch%0d", c+1), 32'(txg[c]), 32'(txw[c]));
    check(z == 0, "R5", "non-zero gap bits", 32'(z), 0);
    check(s == 0, "R4", "sdout moved while bclk high", 32'(s), 0);
    check(vcount == v0 + 1, "R8", "valid pulses per frame", 32'(vcount - v0), 1);
    for (int c = 0; c < CH; c++)
      check(vcap[c] == rxw[c], "R7", $sformatf("rx ch%0d", c+1), 32'(vcap[c]), 32'(rxw[c]));
    check(rx_samples == vcap, "R8", "rx words held after pulse", 0, 0);
  endtask

  task automatic test_reset();
    repeat (5) @(negedge clk);
    check(sdout == 1'b0, "R1", "sdout in reset", 32'(sdout), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(sdout == 1'b0, "R1", "sdout after reset", 32'(sdout), 0);
    check(rx_valid == 1'b0, "R1", "rx_valid after reset", 32'(rx_valid), 0);
    check(rx_samples == '0, "R1", "rx_samples after reset", 0, 0);
    idle_bits(3);
  endtask

  task automatic test_bit_order();
    logic [CH-1:0][SW-1:0] t, r;
    t = '0; r = '0;
    t[0] = 20'h80000; t[5] = 20'h00001;
    r[0] = 20'h80000; r[5] = 20'h00001;
    frame_test("R2", t, r);
  endtask

  task automatic test_channel_map();
    logic [CH-1:0][SW-1:0] t, r;
    for (int c = 0; c < CH; c++) begin
      t[c] = 20'hA0000 | 20'(c * 20'h01111 + 1);
      r[c] = 20'h30000 ^ 20'(c * 20'h02345 + 7);
    end
    frame_test("R3", t, r);
  endtask

  task automatic test_full_scale();
    logic [CH-1:0][SW-1:0] t, r;
    t = {20'h55555, 20'h00000, 20'h00001, 20'hFFFFF, 20'h7FFFF, 20'h80000};
    r = {20'h80000, 20'h7FFFF, 20'hFFFFF, 20'h00001, 20'h00000, 20'hAAAAA};
    frame_test("R10", t, r);
  endtask

  task automatic test_mid_frame_change();
    logic [CH-1:0][SW-1:0] p1, p2, txg;
    int z, s;
    for (int c = 0; c < CH; c++) begin
      p1[c] = 20'(20'h11111 * (c + 1));
      p2[c] = ~p1[c];
    end
    tx_samples = p1;
    tx_pending = p2;
    swap_pos = 10;
    run_frame('0, txg, z, s);
    swap_pos = -1;
    check(txg == p1, "R6", "frame after mid-frame change keeps old words",
          32'(txg[0]), 32'(p1[0]));
    run_frame('0, txg, z, s);
    check(txg == p2, "R6", "next frame carries new words", 32'(txg[0]), 32'(p2[0]));
  endtask

  task automatic test_late_start();
    logic [CH-1:0][SW-1:0] r, txg;
    int z, s, v0;
    for (int c = 0; c < CH; c++) r[c] = 20'(20'h0F0F0 + c);
    tx_samples = {CH{20'h12345}};
    rst_n = 1'b0;
    rel_pos = 30;
    v0 = vcount;
    run_frame(r, txg, z, s);
    rel_pos = -1;
    check(vcount == v0, "R9", "no valid for frame entered mid left half",
          32'(vcount - v0), 0);
    check(txg == '0, "R9", "tx stays zero before first capture", 32'(txg[1]), 0);
    check(rx_samples == '0, "R9", "rx words untouched", 32'(rx_samples[1]), 0);
    frame_test("R3", tx_samples, r);
    check(vcount == v0 + 1, "R9", "valid resumes on next full frame",
          32'(vcount - v0), 1);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  initial begin
    test_reset();
    test_bit_order();
    test_channel_map();
    test_full_scale();
    test_mid_frame_change();
    test_late_start();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog R8: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule